// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns a configuration-space request (bus, device, function, byte offset, length, write data) into one or two 32-bit accesses on a memory-mapped backend. Each access comes with a window value and a word address. The window value selects the configuration cycle type. On Type 0 it also carries the upper part of the one-hot device select.

A request with bus number zero becomes a Type 0 cycle. Its device select bit sits at position `device + IDSEL_LSB`. The bits of that select that fall under `WIN_MASK` go into the window value; the rest go into the address. Any non-zero bus number becomes a Type 1 cycle, and the address then carries the bus, device and function in fixed fields.

Reads return the addressed bytes moved down to bit 0. A 1- or 2-byte write reads the word, replaces the addressed lane and writes the word back. Requests are taken one at a time through a valid/ready pair, and each one ends with a status code and read data on a second valid/ready pair.

Top module: `cfg_xlat`

## Requirements
- R1: With bus 0 (Type 0), the window value is `WIN_T0 | (S & WIN_MASK)` and the address is `CFG_BASE | (S & ~WIN_MASK) | fn<<8 | (off & ~3)`, where S is the single bit at position `dev + 16`.
- R2: A Type 0 request with device 16 or more completes with status 1 (invalid) and read data 0, and makes no backend access.
- R3: With a non-zero bus (Type 1), the window value is `WIN_T1` and the address is `CFG_BASE | bus<<16 | dev<<11 | fn<<8 | (off & ~3)`.
- R4: Every backend address has its two low bits at zero.
- R5: When `single_slot_i` is high, any device number above 1 completes with status 1 and makes no backend access. Devices 0 and 1 are still served.
- R6: A length other than 1, 2 or 4 completes with status 1 and read data 0, and makes no backend access.
- R7: A read makes exactly one backend read. It returns that word shifted right by 8*(off mod 4), masked to 8 bits for length 1, to 16 bits for length 2, and not masked for length 4. The status is 0 (ok).
- R8: A 1- or 2-byte write makes one backend read and then one backend write of the same address. The written word is the read word with the 8- or 16-bit lane at 8*(off mod 4) replaced by the low bytes of the write data.
- R9: A 4-byte write makes no backend read and one backend write of the write data.
- R10: If `be_err_i` is high on a read's acknowledge, the response is status 2 (bus error) with read data 0xFFFFFFFF. If it is high on the read phase of a read-modify-write, the response is status 2 and no write follows.
- R11: After reset `req_ready_o` is high and `rsp_valid_o` and `be_req_o` are low. A response holds its status and data until `rsp_ready_i` is seen, and no new request is taken while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| single_slot_i | input | 1 | Only devices 0 and 1 are reachable |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block is idle and takes the request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Bus number |
| req_dev_i | input | 5 | Device number |
| req_fn_i | input | 3 | Function number |
| req_off_i | input | 8 | Byte offset in configuration space |
| req_len_i | input | 3 | Access length in bytes |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response available |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_status_o | output | 2 | 0 ok, 1 invalid, 2 bus error |
| rsp_rdata_o | output | 32 | Right-aligned read data |
| be_req_o | output | 1 | Backend access request, held until acknowledge |
| be_we_o | output | 1 | Backend access is a write |
| be_addr_o | output | 32 | Backend word address |
| be_win_o | output | 32 | Window value for this access |
| be_wdata_o | output | 32 | Backend write word |
| be_ack_i | input | 1 | Backend access done |
| be_err_i | input | 1 | Backend bus error, valid with acknowledge |
| be_rdata_i | input | 32 | Backend read word, valid with acknowledge |

## Verification
A wrong decode state shows up at once. Either a backend access appears when the request should have been refused, or a valid request returns status 1, and both are visible in the same transaction. If the saved request fields were corrupted, the window value or address seen on the first backend access would differ from the one computed independently from the request. A bad lane merge stays hidden until the word is read back as 32 bits, so every partial write is followed by a full-word read of the same location.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_INVAL  = 2'd1,
    ST_BUSERR = 2'd2
  } rsp_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEC,
    S_RD,
    S_WR,
    S_RSP
  } xlat_state_e;

endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FN_W      = 3,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int SLOT_MAX  = 16,
  parameter int IDSEL_LSB = 16,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [ADDR_W-1:0] WIN_T0   = 32'h0000_0002,
  parameter logic [ADDR_W-1:0] WIN_T1   = 32'h0000_0003
) (
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              single_slot_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] win_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int BUS_LSB = 16;
  localparam int DEV_LSB = 11;
  localparam int FN_LSB  = 8;
  localparam logic [DEV_W-1:0] SLOT_LIM = DEV_W'(SLOT_MAX);
  localparam logic [ADDR_W-1:0] IDSEL_FIELD =
    ((ADDR_W'(1) << SLOT_MAX) - ADDR_W'(1)) << IDSEL_LSB;

  logic              type0;
  logic              len_ok;
  logic              dev_ok;
  logic              slot_ok;
  logic [ADDR_W-1:0] idsel;
  logic [ADDR_W-1:0] route;
  logic [ADDR_W-1:0] lowpart;

  always_comb begin
    type0   = (bus_i == '0);
    len_ok  = (len_i == LEN_W'(1)) || (len_i == LEN_W'(2)) || (len_i == LEN_W'(4));
    dev_ok  = !type0 || (dev_i < SLOT_LIM);
    slot_ok = !single_slot_i || (dev_i <= DEV_W'(1));
    valid_o = len_ok && dev_ok && slot_ok;

    idsel = '0;
    if (dev_i < SLOT_LIM) idsel = ADDR_W'(1) << (IDSEL_LSB + 32'(dev_i));

    if (type0) route = idsel & ~WIN_MASK;
    else       route = (ADDR_W'(bus_i) << BUS_LSB) | (ADDR_W'(dev_i) << DEV_LSB);

    lowpart = (ADDR_W'(fn_i) << FN_LSB) | ADDR_W'({off_i[OFF_W-1:2], 2'b00});
    win_o   = type0 ? (WIN_T0 | (idsel & WIN_MASK)) : WIN_T1;
    addr_o  = valid_o ? (CFG_BASE | route | lowpart) : '0;
  end

  // R1: the device select lands exactly once, in the window or in the address
  always_comb begin
    if (valid_o && type0) begin
      a_r1_idsel_once: assert ($countones(win_o & WIN_MASK) +
                               $countones(addr_o & IDSEL_FIELD & ~WIN_MASK) == 1);
    end
  end

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        byte_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [DATA_W-1:0] merged_o
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] lane;

  always_comb begin
    sh = SH_W'({byte_i, 3'b000});
    case (len_i)
      LEN_W'(1): lane = DATA_W'(8'hFF);
      LEN_W'(2): lane = DATA_W'(16'hFFFF);
      default:   lane = '1;
    endcase
    rd_o = (word_i >> sh) & lane;
    if (len_i == LEN_W'(4)) merged_o = wdata_i;
    else merged_o = (word_i & ~(lane << sh)) | ((wdata_i & lane) << sh);
  end

endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FN_W      = 3,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 3,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int SLOT_MAX  = 16,
  parameter int IDSEL_LSB = 16,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [ADDR_W-1:0] WIN_T0   = 32'h0000_0002,
  parameter logic [ADDR_W-1:0] WIN_T1   = 32'h0000_0003
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              single_slot_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [FN_W-1:0]   req_fn_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_status_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              be_req_o,
  output logic              be_we_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [ADDR_W-1:0] be_win_o,
  output logic [DATA_W-1:0] be_wdata_o,
  input  logic              be_ack_i,
  input  logic              be_err_i,
  input  logic [DATA_W-1:0] be_rdata_i
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  xlat_state_e       st_q, st_d;
  rsp_status_e       sts_q, sts_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic [DATA_W-1:0] wword_q, wword_d;

  logic              r_we;
  logic [BUS_W-1:0]  r_bus;
  logic [DEV_W-1:0]  r_dev;
  logic [FN_W-1:0]   r_fn;
  logic [OFF_W-1:0]  r_off;
  logic [LEN_W-1:0]  r_len;
  logic [DATA_W-1:0] r_wdata;
  logic              r_slot;

  logic              accept;
  logic              req_ok;
  logic [ADDR_W-1:0] gen_win;
  logic [ADDR_W-1:0] gen_addr;
  logic [DATA_W-1:0] lane_rd;
  logic [DATA_W-1:0] lane_merged;

  assign accept = req_valid_i && (st_q == S_IDLE);

  cfg_addr_gen #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W), .LEN_W(LEN_W),
    .ADDR_W(ADDR_W), .SLOT_MAX(SLOT_MAX), .IDSEL_LSB(IDSEL_LSB),
    .WIN_MASK(WIN_MASK), .CFG_BASE(CFG_BASE), .WIN_T0(WIN_T0), .WIN_T1(WIN_T1)
  ) u_addr (
    .bus_i(r_bus), .dev_i(r_dev), .fn_i(r_fn), .off_i(r_off), .len_i(r_len),
    .single_slot_i(r_slot), .valid_o(req_ok), .win_o(gen_win), .addr_o(gen_addr)
  );

  cfg_lane_unit #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_lane (
    .word_i(be_rdata_i), .byte_i(r_off[1:0]), .len_i(r_len), .wdata_i(r_wdata),
    .rd_o(lane_rd), .merged_o(lane_merged)
  );

  // next state
  always_comb begin
    st_d    = st_q;
    sts_d   = sts_q;
    rdat_d  = rdat_q;
    wword_d = wword_q;
    case (st_q)
      S_IDLE: if (req_valid_i) st_d = S_DEC;
      S_DEC: begin
        if (!req_ok) begin
          sts_d  = ST_INVAL;
          rdat_d = '0;
          st_d   = S_RSP;
        end else if (r_we && (r_len == LEN_W'(4))) begin
          wword_d = r_wdata;
          st_d    = S_WR;
        end else begin
          st_d = S_RD;
        end
      end
      S_RD: if (be_ack_i) begin
        if (be_err_i) begin
          sts_d  = ST_BUSERR;
          rdat_d = r_we ? '0 : '1;
          st_d   = S_RSP;
        end else if (!r_we) begin
          sts_d  = ST_OK;
          rdat_d = lane_rd;
          st_d   = S_RSP;
        end else begin
          wword_d = lane_merged;
          st_d    = S_WR;
        end
      end
      S_WR: if (be_ack_i) begin
        sts_d  = be_err_i ? ST_BUSERR : ST_OK;
        rdat_d = '0;
        st_d   = S_RSP;
      end
      S_RSP: if (rsp_ready_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk_i) begin
    sts_q   <= sts_d;
    rdat_q  <= rdat_d;
    wword_q <= wword_d;
    if (accept) begin
      r_we    <= req_we_i;
      r_bus   <= req_bus_i;
      r_dev   <= req_dev_i;
      r_fn    <= req_fn_i;
      r_off   <= req_off_i;
      r_len   <= req_len_i;
      r_wdata <= req_wdata_i;
      r_slot  <= single_slot_i;
    end
  end

  assign req_ready_o  = (st_q == S_IDLE);
  assign rsp_valid_o  = (st_q == S_RSP);
  assign rsp_status_o = sts_q;
  assign rsp_rdata_o  = rdat_q;
  assign be_req_o     = (st_q == S_RD) || (st_q == S_WR);
  assign be_we_o      = (st_q == S_WR);
  assign be_addr_o    = gen_addr;
  assign be_win_o     = gen_win;
  assign be_wdata_o   = wword_q;

  // R11: a pending response blocks new requests
  a_r11_one_at_a_time: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);

  // R11: the response holds until it is taken
  a_r11_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_status_o));

  // R4: word-aligned backend addresses
  a_r4_aligned: assert property (@(posedge clk_i) disable iff (!rst_n)
    be_req_o |-> be_addr_o[1:0] == 2'b00);

  // R8: a partial write is always preceded by an acknowledged read of the same word
  a_r8_rmw_order: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(be_we_o) && (r_len != LEN_W'(4)) |->
      $past(be_req_o && !be_we_o && be_ack_i) && $stable(be_addr_o));

  // R10: a failed read returns all ones
  a_r10_err_ones: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_valid_o && (rsp_status_o == ST_BUSERR) && !r_we |-> rsp_rdata_o == '1);

  // backend request held with a steady address until acknowledged
  a_r3_be_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    be_req_o && !be_ack_i |=> be_req_o && $stable(be_addr_o) && $stable(be_win_o) && $stable(be_we_o));

endmodule

// File: tb/cfg_xlat_tb.sv
module cfg_xlat_tb;

  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [7:0]  off;
    logic [2:0]  len;
    logic [31:0] addr;
    logic [31:0] win;
  } vec_t;

  // read vectors: expected address and window worked out by hand from R1/R3
  localparam vec_t VECS [6] = '{
    '{8'h00, 5'd0,  3'd0, 8'h00, 3'd4, 32'h0C01_0000, 32'h0000_0002},
    '{8'h00, 5'd3,  3'd2, 8'h06, 3'd2, 32'h0C08_0204, 32'h0000_0002},
    '{8'h00, 5'd10, 3'd1, 8'h0D, 3'd1, 32'h0C00_010C, 32'h0400_0002},
    '{8'h00, 5'd15, 3'd7, 8'h3F, 3'd1, 32'h0C00_073C, 32'h8000_0002},
    '{8'h01, 5'd0,  3'd0, 8'h10, 3'd4, 32'h0C01_0010, 32'h0000_0003},
    '{8'h2A, 5'd31, 3'd5, 8'h2B, 3'd2, 32'h0C2A_FD28, 32'h0000_0003}
  };

  logic        clk;
  logic        rst_n;
  logic        single_slot;
  logic        req_valid;
  logic        req_ready;
  logic        req_we;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [7:0]  req_off;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        be_req;
  logic        be_we;
  logic [31:0] be_addr;
  logic [31:0] be_win;
  logic [31:0] be_wdata;
  logic        be_ack;
  logic        be_err;
  logic [31:0] be_rdata;

  int tests;
  int fails;

  cfg_xlat u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .single_slot_i(single_slot),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_bus_i(req_bus), .req_dev_i(req_dev), .req_fn_i(req_fn),
    .req_off_i(req_off), .req_len_i(req_len), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
    .be_req_o(be_req), .be_we_o(be_we), .be_addr_o(be_addr), .be_win_o(be_win),
    .be_wdata_o(be_wdata), .be_ack_i(be_ack), .be_err_i(be_err), .be_rdata_i(be_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // backend model: 64-word memory, one-cycle acknowledge, optional error
  logic [31:0] mem [64];
  logic        err_mode;
  int          n_rd;
  int          n_wr;
  logic [31:0] last_addr;
  logic [31:0] last_win;

  assign be_rdata = mem[be_addr[7:2]];
  assign be_err   = err_mode;

  always @(posedge clk) begin
    if (!rst_n) be_ack <= 1'b0;
    else        be_ack <= be_req && !be_ack;
    if (be_req && be_ack) begin
      if (be_we) begin
        n_wr <= n_wr + 1;
        if (!err_mode) mem[be_addr[7:2]] <= be_wdata;
      end else begin
        n_rd <= n_rd + 1;
        last_addr <= be_addr;
        last_win  <= be_win;
      end
      if (be_we && n_rd == 0) begin
        last_addr <= be_addr;
        last_win  <= be_win;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [1:0]  got_st;
  logic [31:0] got_rd;

  task automatic run(input logic we, input logic [7:0] bus, input logic [4:0] dev,
                     input logic [2:0] fn, input logic [7:0] off, input logic [2:0] len,
                     input logic [31:0] wd);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    req_valid = 1'b1; req_we = we; req_bus = bus; req_dev = dev;
    req_fn = fn; req_off = off; req_len = len; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got_st = rsp_status;
    got_rd = rsp_rdata;
    while (rsp_valid) @(negedge clk);
  endtask

  function automatic logic [31:0] lane_of(input logic [31:0] w, input logic [7:0] off, input logic [2:0] len);
    logic [31:0] s;
    s = w >> (8 * off[1:0]);
    if (len == 3'd1) return s & 32'h0000_00FF;
    if (len == 3'd2) return s & 32'h0000_FFFF;
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] old;
    logic [31:0] exp;
    tests = 0; fails = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h5A3C_961E ^ (i * 32'h0103_0507);
    err_mode = 1'b0; single_slot = 1'b0; rsp_ready = 1'b1;
    req_valid = 1'b0; req_we = 1'b0; req_bus = '0; req_dev = '0; req_fn = '0;
    req_off = '0; req_len = '0; req_wdata = '0;
    n_rd = 0; n_wr = 0; last_addr = '0; last_win = '0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(req_ready && !rsp_valid && !be_req, "R11 reset state", {29'd0, req_ready, rsp_valid, be_req}, 32'h4);

    // table: R1 / R3 address and window, R4 alignment, R7 read lanes
    for (int v = 0; v < 6; v++) begin
      run(1'b0, VECS[v].bus, VECS[v].dev, VECS[v].fn, VECS[v].off, VECS[v].len, 32'h0);
      exp = lane_of(mem[VECS[v].addr[7:2]], VECS[v].off, VECS[v].len);
      chk(last_addr == VECS[v].addr, (VECS[v].bus == 0) ? "R1 address" : "R3 address", last_addr, VECS[v].addr);
      chk(last_win == VECS[v].win, (VECS[v].bus == 0) ? "R1 window" : "R3 window", last_win, VECS[v].win);
      chk(last_addr[1:0] == 2'b00, "R4 alignment", last_addr, VECS[v].addr);
      chk(got_st == 2'd0 && got_rd == exp, "R7 read data", got_rd, exp);
      chk(n_rd == 1 && n_wr == 0, "R7 one read", n_rd, 1);
    end

    // R2 device out of range on Type 0
    run(1'b0, 8'h00, 5'd16, 3'd0, 8'h00, 3'd4, 32'h0);
    chk(got_st == 2'd1 && got_rd == 0, "R2 status", {got_st, got_rd[29:0]}, 32'h4000_0000);
    chk(n_rd == 0 && n_wr == 0, "R2 no access", n_rd + n_wr, 0);

    // R6 bad lengths
    run(1'b0, 8'h00, 5'd1, 3'd0, 8'h00, 3'd3, 32'h0);
    chk(got_st == 2'd1 && got_rd == 0 && n_rd == 0, "R6 len3", got_st, 1);
    run(1'b1, 8'h01, 5'd1, 3'd0, 8'h00, 3'd0, 32'h1234);
    chk(got_st == 2'd1 && n_rd == 0 && n_wr == 0, "R6 len0 write", got_st, 1);

    // R5 single-slot mode
    single_slot = 1'b1;
    run(1'b0, 8'h01, 5'd2, 3'd0, 8'h00, 3'd4, 32'h0);
    chk(got_st == 2'd1 && n_rd == 0, "R5 dev2 refused", got_st, 1);
    run(1'b0, 8'h00, 5'd1, 3'd0, 8'h00, 3'd4, 32'h0);
    chk(got_st == 2'd0 && last_addr == 32'h0C02_0000, "R5 dev1 served", last_addr, 32'h0C02_0000);
    single_slot = 1'b0;

    // R8 byte write at offset 1 on word 0, then full read-back
    old = mem[0];
    run(1'b1, 8'h00, 5'd0, 3'd0, 8'h01, 3'd1, 32'hABCD_EF77);
    exp = (old & 32'hFFFF_00FF) | 32'h0000_7700;
    chk(got_st == 2'd0 && n_rd == 1 && n_wr == 1, "R8 byte rmw accesses", n_rd * 16 + n_wr, 32'h11);
    run(1'b0, 8'h00, 5'd0, 3'd0, 8'h00, 3'd4, 32'h0);
    chk(got_rd == exp, "R8 byte merged word", got_rd, exp);

    // R8 halfword write at offset 6 on word 1
    old = mem[1];
    run(1'b1, 8'h00, 5'd3, 3'd2, 8'h06, 3'd2, 32'h5555_BEEF);
    exp = (old & 32'h0000_FFFF) | 32'hBEEF_0000;
    run(1'b0, 8'h00, 5'd3, 3'd2, 8'h04, 3'd4, 32'h0);
    chk(got_rd == exp, "R8 half merged word", got_rd, exp);

    // R9 full-word write
    run(1'b1, 8'h01, 5'd0, 3'd0, 8'h10, 3'd4, 32'hC001_D00D);
    chk(got_st == 2'd0 && n_rd == 0 && n_wr == 1, "R9 single write", n_rd * 16 + n_wr, 32'h01);
    chk(mem[4] == 32'hC001_D00D, "R9 word stored", mem[4], 32'hC001_D00D);

    // R10 bus errors
    err_mode = 1'b1;
    run(1'b0, 8'h00, 5'd3, 3'd2, 8'h06, 3'd2, 32'h0);
    chk(got_st == 2'd2 && got_rd == 32'hFFFF_FFFF, "R10 read all ones", got_rd, 32'hFFFF_FFFF);
    run(1'b1, 8'h00, 5'd3, 3'd2, 8'h06, 3'd1, 32'h11);
    chk(got_st == 2'd2 && n_wr == 0, "R10 rmw aborted", n_wr, 0);
    err_mode = 1'b0;

    // R11 response held while not taken
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_bus = 8'h00; req_dev = 5'd0;
    req_fn = 3'd0; req_off = 8'h00; req_len = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got_rd = rsp_rdata;
    repeat (3) @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_rdata == got_rd, "R11 hold", rsp_rdata, got_rd);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11 release", {30'd0, rsp_valid, req_ready}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule